// File: doc/BRIEF.md
# Hierarchical Page Table Walker (64-bit descriptors, levels 0 to 3)

This block resolves one virtual address to a physical address by reading 64-bit descriptors from a multi-level page table. A request carries the virtual address, the address of the root table, a granule code (4 KB, 16 KB or 64 KB) and the level at which the walk starts. At each level the walker issues one read on a ready/valid descriptor-fetch channel and waits for the returned descriptor. It then decodes that descriptor as a pointer to the next table, a block, a page or an invalid entry. The walk ends with a one-cycle result that carries either a fault and the level that faulted, or the physical address, the mapping size, the leaf attributes and the effective permissions.

Table descriptors carry restrictions that apply to every level below them. The walker gathers these restrictions in sticky bits and folds them into the leaf permissions. A leaf whose access flag is clear is still translated, and the result flags it so that the flag can be set and the entry marked dirty. Only one walk is in flight at a time.

The control is a four-state machine. IDLE accepts a request. It moves to FETCH, or straight to DONE when the granule code is reserved. FETCH holds a descriptor read until that read is accepted, then moves to WAIT. WAIT takes the returned descriptor: a table sends it back to FETCH with the next level's address, and a leaf or an invalid entry sends it to DONE. DONE presents the result for one cycle and returns to IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only in IDLE. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low from that point until the cycle after the result, whatever `req_valid` does meanwhile.
- R2: The first read address is the root address with bits [2:0] forced to zero, ORed with the start-level index shifted left by 3. The granule code is 0 for 4 KB (g=12), 1 for 16 KB (g=14) and 2 for 64 KB (g=16). With stride s=g-3, the index at level L is virtual-address bits [lo+s-1:lo], where lo=s*(3-L)+g. Virtual-address bits above 47 read as zero.
- R3: A descriptor with bits [1:0]=3 at levels 0 to 2 is a table. The next read goes to level L+1 at address (descriptor bits [47:g] with g low zero bits) ORed with that level's index shifted left by 3.
- R4: Bits [1:0]=3 at level 3 is a page. Bits [1:0]=1 is a block only at levels 1 and 2 with the 4 KB granule, and only at level 2 with the 16 KB or 64 KB granule.
- R5: Bits [1:0] of 0 or 2, or a block code at a level where blocks are not allowed, ends the walk with `res_fault`=1 and `res_level` set to that level. No further read is issued and `res_af_miss` is 0.
- R6: For a leaf, the offset width n is 30 for a level-1 block and 21 for a level-2 block (4 KB), 25 for a level-2 block (16 KB), 29 for a level-2 block (64 KB), and g for a page. `res_pa` is descriptor bits [47:n] joined with virtual-address bits [n-1:0], and `res_size` is n.
- R7: A leaf result passes through not-global (bit 11) to `res_ng`, the contiguous hint (bit 52) to `res_contig`, shareability (bits [9:8]) to `res_sh`, and the attribute index (bits [4:2]) to `res_attr`.
- R8: Each table descriptor contributes restrictions: bit 63 forces non-secure, bit 62 forces read-only, bit 61 forbids user access, bit 60 forces execute-never and bit 59 forces privileged execute-never. The result gives `res_xn`=bit54 OR any bit60, `res_pxn`=bit53 OR any bit59, `res_ns`=bit5 OR any bit63, `res_ap[1]`=bit7 OR any bit62, and `res_ap[0]`=bit6 AND NOT any bit61.
- R9: A leaf with access flag bit 10 clear gives `res_af_miss`=1, and a leaf with bit 10 set gives 0.
- R10: Once `rd_valid` is high, it stays high with `rd_addr` unchanged until a cycle with `rd_ready` high. A returned descriptor is taken only when `rsp_valid` is high in WAIT, after any number of cycles of delay.
- R11: `res_valid` is high for exactly one cycle, and the walker is idle in the cycle after it.
- R12: Granule code 3 ends the walk at once with `res_fault`=1, `res_level` equal to the start level, and no read.
- R13: After reset, `req_ready`=1, `rd_valid`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 48 | Virtual address to translate |
| req_root | input | 48 | Root table address |
| req_gran | input | 2 | Granule code: 0=4 KB, 1=16 KB, 2=64 KB, 3 reserved |
| req_level | input | 2 | Starting lookup level |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 48 | Descriptor byte address, 8-byte aligned |
| rsp_valid | input | 1 | Returned descriptor present |
| rsp_data | input | 64 | Returned descriptor |
| res_valid | output | 1 | Walk result, one-cycle pulse |
| res_fault | output | 1 | Translation fault |
| res_level | output | 2 | Level at which the walk ended |
| res_pa | output | 48 | Physical address |
| res_size | output | 5 | Offset width n (log2 of mapping size) |
| res_xn | output | 1 | Effective execute-never |
| res_pxn | output | 1 | Effective privileged execute-never |
| res_ap | output | 2 | Effective access permission {read-only, user} |
| res_ns | output | 1 | Effective non-secure |
| res_ng | output | 1 | Not-global |
| res_af_miss | output | 1 | Leaf access flag was clear |
| res_attr | output | 3 | Attribute index |
| res_sh | output | 2 | Shareability |
| res_contig | output | 1 | Contiguous hint |

## Verification
The widths are fixed by the descriptor format, so the bench builds the block as it stands. It sweeps every granule code, every start level and every ending level. At each end point it uses a legal leaf, an invalid code, and a block code where blocks are not allowed, so every legality corner of the type decode and every offset width is hit. The bench varies read stalls, response delays and a request held high during the walk. Random descriptor contents exercise the permission folding over walks of one to four levels.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int unsigned PA_W   = 48;
    localparam int unsigned DESC_W = 64;
    localparam int unsigned LVL_W  = 2;
    localparam int unsigned OFF_W  = 5;

    typedef enum logic [1:0] {
        GR_4K  = 2'd0,
        GR_16K = 2'd1,
        GR_64K = 2'd2,
        GR_RSV = 2'd3
    } gran_e;

    typedef enum logic [1:0] {
        DK_INVALID,
        DK_TABLE,
        DK_BLOCK,
        DK_PAGE
    } dkind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } wstate_e;

    // Sticky restrictions gathered from table descriptors (bits 63:59).
    typedef struct packed {
        logic       ns;
        logic [1:0] ap;
        logic       xn;
        logic       pxn;
    } limit_t;

    function automatic logic [OFF_W-1:0] gran_shift(input logic [1:0] gr);
        logic [OFF_W-1:0] sh;
        case (gr)
            GR_4K:   sh = OFF_W'(12);
            GR_16K:  sh = OFF_W'(14);
            default: sh = OFF_W'(16);
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pgwalk_index.sv
module pgwalk_index
    import pgwalk_pkg::*;
(
    input  logic [PA_W-1:0]  va,
    input  logic [PA_W-1:0]  base,
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       gran,
    output logic [PA_W-1:0]  addr
);

    localparam int unsigned EXT_W = DESC_W;

    logic [OFF_W-1:0] g_sh;
    logic [OFF_W-1:0] stride;
    logic [5:0]       lo;
    logic [EXT_W-1:0] va_ext;
    logic [EXT_W-1:0] field;

    always_comb begin
        g_sh   = gran_shift(gran);
        stride = g_sh - OFF_W'(3);
        lo     = 6'(stride) * 6'(LVL_W'(3) - level) + 6'(g_sh);
        va_ext = EXT_W'(va);
        field  = (va_ext >> lo) & ((EXT_W'(1) << stride) - EXT_W'(1));
        addr   = (base & ~PA_W'(7)) | PA_W'(field << 3);
    end

endmodule

// File: rtl/pgwalk_decode.sv
module pgwalk_decode
    import pgwalk_pkg::*;
(
    input  logic [PA_W-1:0]  desc,
    input  logic [PA_W-1:0]  va,
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       gran,
    output dkind_e           kind,
    output logic [OFF_W-1:0] off_w,
    output logic [PA_W-1:0]  leaf_pa,
    output logic [PA_W-1:0]  next_base
);

    logic             blk_legal;
    logic [OFF_W-1:0] g_sh;
    logic [PA_W-1:0]  off_mask;
    logic [PA_W-1:0]  g_mask;

    always_comb begin
        g_sh      = gran_shift(gran);
        blk_legal = (gran == GR_4K) ? (level == 2'd1 || level == 2'd2)
                                    : (level == 2'd2);
        unique case (desc[1:0])
            2'b11:   kind = (level == 2'd3) ? DK_PAGE : DK_TABLE;
            2'b01:   kind = blk_legal ? DK_BLOCK : DK_INVALID;
            default: kind = DK_INVALID;
        endcase

        off_w = g_sh;
        if (kind == DK_BLOCK) begin
            unique case (gran)
                GR_4K:   off_w = (level == 2'd1) ? OFF_W'(30) : OFF_W'(21);
                GR_16K:  off_w = OFF_W'(25);
                default: off_w = OFF_W'(29);
            endcase
        end

        off_mask  = (PA_W'(1) << off_w) - PA_W'(1);
        g_mask    = (PA_W'(1) << g_sh) - PA_W'(1);
        leaf_pa   = (desc & ~off_mask) | (va & off_mask);
        next_base = desc & ~g_mask;
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [47:0]       req_va,
    input  logic [47:0]       req_root,
    input  logic [1:0]        req_gran,
    input  logic [1:0]        req_level,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [47:0]       rd_addr,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_data,
    output logic              res_valid,
    output logic              res_fault,
    output logic [1:0]        res_level,
    output logic [47:0]       res_pa,
    output logic [4:0]        res_size,
    output logic              res_xn,
    output logic              res_pxn,
    output logic [1:0]        res_ap,
    output logic              res_ns,
    output logic              res_ng,
    output logic              res_af_miss,
    output logic [2:0]        res_attr,
    output logic [1:0]        res_sh,
    output logic              res_contig
);

    wstate_e          state, state_nx;
    logic [PA_W-1:0]  va_q;
    logic [1:0]       gran_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PA_W-1:0]  addr_q;
    limit_t           lim_q;

    dkind_e           dc_kind;
    logic [OFF_W-1:0] dc_off;
    logic [PA_W-1:0]  dc_pa;
    logic [PA_W-1:0]  dc_next_base;

    logic [PA_W-1:0]  ix_va;
    logic [PA_W-1:0]  ix_base;
    logic [LVL_W-1:0] ix_lvl;
    logic [1:0]       ix_gran;
    logic [PA_W-1:0]  ix_addr;

    limit_t           tbl_lim;
    logic             take_req;
    logic             take_rsp;
    logic             desc_unused;

    assign desc_unused = ^{rsp_data[58:55], rsp_data[51:48]};
    assign tbl_lim     = limit_t'(rsp_data[63:59]);
    assign take_req    = (state == ST_IDLE) && req_valid;
    assign take_rsp    = (state == ST_WAIT) && rsp_valid;

    // One index generator serves both the root fetch and every table hop.
    assign ix_va   = (state == ST_IDLE) ? req_va    : va_q;
    assign ix_base = (state == ST_IDLE) ? req_root  : dc_next_base;
    assign ix_lvl  = (state == ST_IDLE) ? req_level : LVL_W'(lvl_q + LVL_W'(1));
    assign ix_gran = (state == ST_IDLE) ? req_gran  : gran_q;

    pgwalk_index u_index (
        .va    (ix_va),
        .base  (ix_base),
        .level (ix_lvl),
        .gran  (ix_gran),
        .addr  (ix_addr)
    );

    pgwalk_decode u_decode (
        .desc      (rsp_data[PA_W-1:0]),
        .va        (va_q),
        .level     (lvl_q),
        .gran      (gran_q),
        .kind      (dc_kind),
        .off_w     (dc_off),
        .leaf_pa   (dc_pa),
        .next_base (dc_next_base)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = (req_gran == GR_RSV) ? ST_DONE : ST_FETCH;
            ST_FETCH: if (rd_ready)  state_nx = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_nx = (dc_kind == DK_TABLE) ? ST_FETCH : ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rd_valid  = (state == ST_FETCH);
        res_valid = (state == ST_DONE);
        rd_addr   = addr_q;
    end

    // Walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            gran_q      <= '0;
            lvl_q       <= '0;
            addr_q      <= '0;
            lim_q       <= '0;
            res_fault   <= 1'b0;
            res_level   <= '0;
            res_pa      <= '0;
            res_size    <= '0;
            res_xn      <= 1'b0;
            res_pxn     <= 1'b0;
            res_ap      <= '0;
            res_ns      <= 1'b0;
            res_ng      <= 1'b0;
            res_af_miss <= 1'b0;
            res_attr    <= '0;
            res_sh      <= '0;
            res_contig  <= 1'b0;
        end else if (take_req) begin
            va_q   <= req_va;
            gran_q <= req_gran;
            lvl_q  <= req_level;
            addr_q <= ix_addr;
            lim_q  <= '0;
            if (req_gran == GR_RSV) begin
                res_fault   <= 1'b1;
                res_level   <= req_level;
                res_af_miss <= 1'b0;
            end
        end else if (take_rsp) begin
            unique case (dc_kind)
                DK_TABLE: begin
                    lim_q  <= lim_q | tbl_lim;
                    lvl_q  <= ix_lvl;
                    addr_q <= ix_addr;
                end
                DK_INVALID: begin
                    res_fault   <= 1'b1;
                    res_level   <= lvl_q;
                    res_af_miss <= 1'b0;
                end
                default: begin
                    res_fault   <= 1'b0;
                    res_level   <= lvl_q;
                    res_pa      <= dc_pa;
                    res_size    <= dc_off;
                    res_xn      <= rsp_data[54] | lim_q.xn;
                    res_pxn     <= rsp_data[53] | lim_q.pxn;
                    res_ap      <= {rsp_data[7] | lim_q.ap[1], rsp_data[6] & ~lim_q.ap[0]};
                    res_ns      <= rsp_data[5] | lim_q.ns;
                    res_ng      <= rsp_data[11];
                    res_af_miss <= ~rsp_data[10];
                    res_attr    <= rsp_data[4:2];
                    res_sh      <= rsp_data[9:8];
                    res_contig  <= rsp_data[52];
                end
            endcase
        end
    end

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [47:0] rd_addr,
    input logic        res_valid,
    input logic        res_fault,
    input logic        res_af_miss
);

    // R1
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R11
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    // R11
    result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!req_ready && !rd_valid));

    // R5
    fault_no_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> !res_af_miss);

endmodule

bind pgwalk_top pgwalk_chk u_chk (.*);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [47:0] req_root = '0;
    logic [1:0]  req_gran = '0;
    logic [1:0]  req_level = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [47:0] rd_addr;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        res_valid, res_fault, res_xn, res_pxn, res_ns, res_ng, res_af_miss, res_contig;
    logic [1:0]  res_level, res_ap, res_sh;
    logic [47:0] res_pa;
    logic [4:0]  res_size;
    logic [2:0]  res_attr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    logic [63:0] dsc [4];
    logic [63:0] eadr [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwalk_top u_dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] rnd();
        seed = seed * 64'h5851_F42D_4C95_7F2D + 64'h1405_7B7E_F767_814F;
        return seed ^ (seed >> 29);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int gsh(input int g);
        return 12 + 2 * g;
    endfunction

    function automatic logic [63:0] idx_addr(input logic [63:0] base, input logic [63:0] va,
                                             input int lvl, input int g);
        int st = gsh(g) - 3;
        int lo = st * (3 - lvl) + gsh(g);
        logic [63:0] f = (va >> lo) & ((64'd1 << st) - 64'd1);
        return ((base & ~64'd7) | (f << 3)) & M48;
    endfunction

    function automatic bit blk_ok(input int g, input int f);
        return (g == 0) ? (f == 1 || f == 2) : (f == 2);
    endfunction

    function automatic int leaf_n(input int g, input int f);
        if (f == 3) return gsh(g);
        if (g == 0) return (f == 1) ? 30 : 21;
        return (g == 1) ? 25 : 29;
    endfunction

    // g: granule, s: start level, f: end level, k: leaf variant,
    // stall: rd_ready hold-off, dly: response delay, hold: keep req_valid high
    task automatic run_walk(input int g, input int s, input int f, input int k,
                            input int stall, input int dly, input bit hold);
        logic [63:0] va = rnd() & M48;
        logic [63:0] root = rnd() & M48;
        logic [63:0] base = root & ~64'd7;
        logic [4:0] lim = '0;
        logic [1:0] code = 2'd0;
        logic [63:0] d = '0;
        logic [63:0] nb;
        logic [63:0] e_pa;
        logic [63:0] omask;
        bit exp_fault;
        bit got = 0;
        bit busy_bad = 0;
        int nf = f - s + 1;
        int kf = 0;
        int nr = 0;
        int rsp_cnt = 0;
        int stall_left = stall;
        int iter = 0;
        int n;
        for (int L = s; L <= f; L++) begin
            eadr[L-s] = idx_addr(base, va, L, g);
            if (L < f) begin
                nb = rnd() & M48 & ~((64'd1 << gsh(g)) - 64'd1);
                d = rnd();
                d[47:0] = (d[47:0] & 48'(((64'd1 << gsh(g)) - 64'd1))) | nb[47:0];
                d[1:0] = 2'b11;
                lim = lim | d[63:59];
                base = nb;
            end else begin
                d = rnd();
                if (k == 0)      code = (f == 3) ? 2'd3 : 2'd1;
                else if (k == 1) code = d[20] ? 2'd0 : 2'd2;
                else             code = 2'd1;
                d[1:0] = code;
            end
            dsc[L-s] = d;
        end
        exp_fault = (code == 2'd0) || (code == 2'd2) || (code == 2'd1 && !blk_ok(g, f));

        req_va = va[47:0]; req_root = root[47:0];
        req_gran = 2'(g); req_level = 2'(s); req_valid = 1'b1;
        @(negedge clk);
        if (hold) req_va = ~req_va;
        else      req_valid = 1'b0;

        while (!got && iter < 200) begin
            iter++;
            rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data = (nr < 4) ? dsc[nr] : 64'd0;
                    nr++;
                end
            end
            if (req_ready) busy_bad = 1;
            rd_ready = 1'b0;
            if (res_valid) begin
                got = 1;
                req_valid = 1'b0;
            end else if (rd_valid) begin
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    rd_ready = 1'b1;
                    if (kf < nf) chk((kf == 0) ? "R2 root fetch address" : "R3 table hop address",
                                     64'(rd_addr), eadr[kf]);
                    else chk("R5 no read after leaf/fault", 64'(kf), 64'(nf));
                    kf++;
                    rsp_cnt = 1 + dly;
                    stall_left = stall;
                end
            end
            if (!got) @(negedge clk);
        end

        chk("R1 walk completes / busy while walking", {63'd0, busy_bad | !got}, 64'd0);
        chk("R4 R5 number of levels read", 64'(kf), 64'(nf));
        chk("R4 R5 fault flag", 64'(res_fault), 64'(exp_fault));
        chk("R5 R6 result level", 64'(res_level), 64'(f));
        if (exp_fault) begin
            chk("R5 no access-flag report on fault", 64'(res_af_miss), 64'd0);
        end else begin
            n = leaf_n(g, f);
            omask = (64'd1 << n) - 64'd1;
            e_pa = ((d & ~omask) | (va & omask)) & M48;
            chk("R6 physical address", 64'(res_pa), e_pa);
            chk("R6 size", 64'(res_size), 64'(n));
            // lim = {ns, ro, nouser, xn, pxn}
            chk("R8 folded permissions", 64'({res_xn, res_pxn, res_ap, res_ns}),
                64'({d[54] | lim[1], d[53] | lim[0], d[7] | lim[3], d[6] & ~lim[2], d[5] | lim[4]}));
            chk("R7 leaf fields", 64'({res_ng, res_contig, res_sh, res_attr}),
                64'({d[11], d[52], d[9:8], d[4:2]}));
            chk("R9 access flag report", 64'(res_af_miss), 64'(!d[10]));
        end
        rsp_valid = 1'b0;
        @(negedge clk);
        chk("R11 pulse ends and walker idle", 64'({res_valid, req_ready}), 64'b01);
    endtask

    initial begin
        int w = 0;
        repeat (3) @(negedge clk);
        chk("R13 reset state", 64'({req_ready, rd_valid, res_valid}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 idle after reset", 64'({req_ready, rd_valid, res_valid}), 64'b100);

        for (int g = 0; g < 3; g++)
            for (int s = 0; s < 4; s++)
                for (int f = s; f < 4; f++)
                    for (int k = 0; k < 3; k++) begin
                        if (k == 2 && f != 3) continue;
                        run_walk(g, s, f, k, w % 3, (w / 3) % 3, (w % 5) == 4);
                        w++;
                    end

        // R12: reserved granule code faults at the start level without a read
        for (int s = 0; s < 4; s++) begin
            req_va = rnd()[47:0]; req_root = rnd()[47:0];
            req_gran = 2'd3; req_level = 2'(s); req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R12 reserved granule result", 64'({res_valid, res_fault, res_level, rd_valid}),
                64'({1'b1, 1'b1, 2'(s), 1'b0}));
            @(negedge clk);
            chk("R12 idle after reserved granule", 64'({res_valid, req_ready, rd_valid}), 64'b010);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule